// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Latch

This block collects interrupt vectors that arrive from a point-to-point link as messages and turns them into a level request towards the processor. It holds a 256-bit pending set split into eight 32-bit groups. Each group has a 32-bit enable word beside it. Vector decoding from link packets happens upstream. Here a vector arrives as a one-cycle valid strobe with an 8-bit index. The upper three index bits pick the group and the lower five pick the bit.

Software reaches every word over a simple 32-bit register port with a one-cycle read latency. Pending group g sits at byte offset 4*g (0x00 to 0x1C). Enable group g sits at byte offset 0x20 + 4*g (0x20 to 0x3C). A handler reads a pending word and writes ones back to retire the bits it has serviced. A typical setup enables only vectors 0 to 15 by writing 0x0000FFFF to enable group 0. In that setup a pending bit in group 0 above position 15 is unexpected, and a dedicated output flags it. All parent request lines assert together whenever anything is pending.

Top module: `htvec_latch`

## Requirements
- R1: While reset is high at a clock edge, every pending and enable bit is cleared. At the following edge `irq_out`, `spurious` and `reg_rdata` are all zero.
- R2: A write to byte offset 0x20 + 4*g replaces all 32 bits of enable group g. A read of that offset returns the stored word.
- R3: A strobe on `vec_valid` with index v sets pending bit v[4:0] of group v[7:5] if that bit's enable is set at that edge. A read of offset 4*g returns pending group g.
- R4: An arriving vector whose enable bit is clear is dropped, and its pending bit stays 0.
- R5: A write to pending offset 4*g clears each pending bit whose data bit is 1 and leaves each bit whose data bit is 0 unchanged. Such a write never sets a bit.
- R6: If a clearing write and an enabled arrival hit the same pending bit at the same edge, the bit stays set.
- R7: All four `irq_out` lines are 1 in the cycle after any of the 256 pending bits is 1. They are 0 in the cycle after none is.
- R8: A read of an unmapped byte offset returns zero, and a write to one changes no pending or enable bit. Unmapped means offsets of 0x40 and above, or offsets whose two low bits are not zero.
- R9: `spurious` is 1 in the cycle after any pending bit 16 to 31 of group 0 is 1, and 0 otherwise.
- R10: `reg_rdata` is updated at the edge that samples `reg_re` and holds the state from before that edge. In cycles without a read it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vec_valid | input | 1 | Vector arrival strobe |
| vec_index | input | 8 | Index of the arriving vector |
| reg_addr | input | 8 | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq_out | output | 4 | Parent request lines, all driven alike |
| spurious | output | 1 | Unexpected vector above 15 pending in group 0 |

## Verification
A vector or write at edge k changes the pending and enable state at edge k. `irq_out` and `spurious` follow at edge k+1, and read data appears at the edge that samples the read. The bench drives inputs on falling edges. A behavioural model steps at each rising edge, taking its registered outputs from its state before the update, and then applies writes and arrivals. Every falling edge compares all three outputs against the model, so each latency is checked exactly at the cycle it is due. Same-edge cases are driven on purpose: a read together with an arrival, a clear together with an arrival, and an enable write together with an arrival.

// File: rtl/htvl_pkg.sv
package htvl_pkg;
  // Region selected by a register byte offset
  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_PEND = 2'd1,
    REG_EN   = 2'd2
  } reg_region_e;
endpackage

// File: rtl/htvl_group.sv
// One 32-vector group: pending and enable storage with set/clear merge.
module htvl_group #(
  parameter int W = 32,
  localparam int BW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_vld,
  input  logic [BW-1:0] set_bit,
  input  logic          clr_we,
  input  logic          en_we,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  pend_q,
  output logic [W-1:0]  en_q
);
  logic [W-1:0] set_mask;
  logic [W-1:0] clr_mask;

  always_comb begin
    set_mask = set_vld ? ((W'(1) << set_bit) & en_q) : '0;
    clr_mask = clr_we ? wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      if (en_we) en_q <= wdata;
      // arrival is merged after the clear so it wins on a collision
      pend_q <= (pend_q & ~clr_mask) | set_mask;
    end
  end

  assert_drop_disabled_R4: assert property (@(posedge clk) disable iff (rst)
    (set_vld && !en_q[set_bit] && !pend_q[set_bit]) |=> !pend_q[$past(set_bit)]);

  assert_arrival_wins_R6: assert property (@(posedge clk) disable iff (rst)
    (set_vld && en_q[set_bit] && clr_we) |=> pend_q[$past(set_bit)]);

  assert_clear_ones_R5: assert property (@(posedge clk) disable iff (rst)
    (clr_we && !set_vld) |=> ((pend_q & $past(wdata)) == '0));
endmodule

// File: rtl/htvl_regbus.sv
// Register decode and registered read mux.
module htvl_regbus
  import htvl_pkg::*;
#(
  parameter int NG      = 8,
  parameter int W       = 32,
  parameter int AW      = 8,
  parameter int EN_BASE = 32,
  localparam int GI_W   = $clog2(NG),
  localparam int SPAN   = NG * 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [AW-1:0]  addr,
  input  logic           we,
  input  logic           re,
  input  logic [NG*W-1:0] pend_flat,
  input  logic [NG*W-1:0] en_flat,
  output logic [NG-1:0]  clr_we,
  output logic [NG-1:0]  en_we,
  output logic [W-1:0]   rdata_q
);
  localparam logic [AW-1:0] PEND_LIM = AW'(SPAN);
  localparam logic [AW-1:0] EN_LO    = AW'(EN_BASE);

  reg_region_e      region;
  logic [AW-1:0]    en_off;
  logic [GI_W-1:0]  widx;
  logic [W-1:0]     rd_next;

  always_comb begin
    en_off = addr - EN_LO;
    region = REG_NONE;
    widx   = '0;
    if (addr[1:0] == 2'b00) begin
      if (addr < PEND_LIM) begin
        region = REG_PEND;
        widx   = addr[GI_W+1:2];
      end else if (addr >= EN_LO && en_off < PEND_LIM) begin
        region = REG_EN;
        widx   = en_off[GI_W+1:2];
      end
    end
  end

  always_comb begin
    for (int g = 0; g < NG; g++) begin
      clr_we[g] = we && (region == REG_PEND) && (widx == GI_W'(g));
      en_we[g]  = we && (region == REG_EN)   && (widx == GI_W'(g));
    end
    case (region)
      REG_PEND: rd_next = pend_flat[widx*W +: W];
      REG_EN:   rd_next = en_flat[widx*W +: W];
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata_q <= '0;
    else if (re) rdata_q <= rd_next;
    else         rdata_q <= '0;
  end

  assert_idle_read_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !re |=> (rdata_q == '0));

  assert_one_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    $countones({clr_we, en_we}) <= 1);
endmodule

// File: rtl/htvl_combine.sv
// Reduces all pending bits to the parent lines and the spurious flag.
module htvl_combine #(
  parameter int NG  = 8,
  parameter int W   = 32,
  parameter int NP  = 4,
  parameter int LEG = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NG*W-1:0] pend_flat,
  output logic [NP-1:0]   irq_q,
  output logic            spur_q
);
  logic any_pend;
  logic high_pend;

  always_comb begin
    any_pend  = |pend_flat;
    high_pend = |pend_flat[W-1:LEG];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q  <= '0;
      spur_q <= 1'b0;
    end else begin
      irq_q  <= {NP{any_pend}};
      spur_q <= high_pend;
    end
  end

  assert_irq_raise_R7: assert property (@(posedge clk) disable iff (rst)
    (pend_flat != '0) |=> (irq_q == {NP{1'b1}}));

  assert_irq_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (pend_flat == '0) |=> (irq_q == '0));

  assert_spur_R9: assert property (@(posedge clk) disable iff (rst)
    (pend_flat[W-1:LEG] != '0) |=> spur_q);
endmodule

// File: rtl/htvec_latch.sv
module htvec_latch #(
  parameter int NUM_GROUPS  = 8,
  parameter int GROUP_W     = 32,
  parameter int NUM_PARENTS = 4,
  parameter int LEGACY_VECS = 16,
  parameter int ADDR_W      = 8,
  parameter int EN_BASE     = 32,
  localparam int BIT_W      = $clog2(GROUP_W),
  localparam int GSEL_W     = $clog2(NUM_GROUPS),
  localparam int IDX_W      = BIT_W + GSEL_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   vec_valid,
  input  logic [IDX_W-1:0]       vec_index,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic                   reg_we,
  input  logic                   reg_re,
  input  logic [GROUP_W-1:0]     reg_wdata,
  output logic [GROUP_W-1:0]     reg_rdata,
  output logic [NUM_PARENTS-1:0] irq_out,
  output logic                   spurious
);
  logic [NUM_GROUPS*GROUP_W-1:0] pend_flat;
  logic [NUM_GROUPS*GROUP_W-1:0] en_flat;
  logic [NUM_GROUPS-1:0]         clr_we;
  logic [NUM_GROUPS-1:0]         en_we;

  htvl_regbus #(
    .NG(NUM_GROUPS), .W(GROUP_W), .AW(ADDR_W), .EN_BASE(EN_BASE)
  ) u_regbus (
    .clk(clk), .rst(rst), .addr(reg_addr), .we(reg_we), .re(reg_re),
    .pend_flat(pend_flat), .en_flat(en_flat),
    .clr_we(clr_we), .en_we(en_we), .rdata_q(reg_rdata)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic hit;
    assign hit = vec_valid && (vec_index[IDX_W-1:BIT_W] == GSEL_W'(g));
    htvl_group #(.W(GROUP_W)) u_group (
      .clk(clk), .rst(rst),
      .set_vld(hit), .set_bit(vec_index[BIT_W-1:0]),
      .clr_we(clr_we[g]), .en_we(en_we[g]), .wdata(reg_wdata),
      .pend_q(pend_flat[g*GROUP_W +: GROUP_W]),
      .en_q(en_flat[g*GROUP_W +: GROUP_W])
    );
  end

  htvl_combine #(
    .NG(NUM_GROUPS), .W(GROUP_W), .NP(NUM_PARENTS), .LEG(LEGACY_VECS)
  ) u_combine (
    .clk(clk), .rst(rst), .pend_flat(pend_flat),
    .irq_q(irq_out), .spur_q(spurious)
  );

  // byte offsets that map to no register
  logic unmapped;
  always_comb begin
    unmapped = (reg_addr[1:0] != 2'b00) ||
               ((int'(reg_addr) >= NUM_GROUPS*4) && (int'(reg_addr) < EN_BASE)) ||
               (int'(reg_addr) >= EN_BASE + NUM_GROUPS*4);
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (pend_flat == '0 && en_flat == '0));

  assert_unmapped_write_R8: assert property (@(posedge clk) disable iff (rst)
    (reg_we && unmapped) |=> ($stable(en_flat) && (($past(pend_flat) & ~pend_flat) == '0)));
endmodule

// File: tb/htvec_latch_tb.sv
module htvec_latch_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        vec_valid;
  logic [7:0]  vec_index;
  logic [7:0]  reg_addr;
  logic        reg_we;
  logic        reg_re;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [3:0]  irq_out;
  logic        spurious;

  always #5 clk = ~clk;

  htvec_latch u_dut (
    .clk(clk), .rst(rst), .vec_valid(vec_valid), .vec_index(vec_index),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_re(reg_re),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out), .spurious(spurious)
  );

  int checks = 0;
  int errors = 0;
  int cyc_n  = 0;
  string tag = "R1";

  // behavioural reference
  logic [31:0] m_pend [8];
  logic [31:0] m_en   [8];
  logic [3:0]  e_irq;
  logic        e_spur;
  logic [31:0] e_rd;

  // returns 0 none, 1 pending, 2 enable; idx out
  function automatic int decode(input int a, output int idx);
    idx = 0;
    if (a % 4 != 0) return 0;
    if (a < 32) begin idx = a / 4; return 1; end
    if (a < 64) begin idx = (a - 32) / 4; return 2; end
    return 0;
  endfunction

  always @(posedge clk) begin
    cyc_n++;
    if (rst) begin
      for (int g = 0; g < 8; g++) begin m_pend[g] = 0; m_en[g] = 0; end
      e_irq = 0; e_spur = 0; e_rd = 0;
    end else begin
      int kind, idx, vg, vb;
      bit any, do_set;
      any = 0;
      for (int g = 0; g < 8; g++) if (m_pend[g] != 0) any = 1;
      e_irq  = any ? 4'hF : 4'h0;
      e_spur = (m_pend[0][31:16] != 0);
      e_rd   = 0;
      kind = decode(int'(reg_addr), idx);
      if (reg_re) begin
        if (kind == 1) e_rd = m_pend[idx];
        else if (kind == 2) e_rd = m_en[idx];
      end
      vg = int'(vec_index) / 32;
      vb = int'(vec_index) % 32;
      do_set = vec_valid && m_en[vg][vb];
      if (reg_we) begin
        if (kind == 1) m_pend[idx] = m_pend[idx] & ~reg_wdata;
        else if (kind == 2) m_en[idx] = reg_wdata;
      end
      if (do_set) m_pend[vg][vb] = 1'b1;
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cyc_n > 0) begin
      chk("irq_out (R7)", {28'd0, irq_out}, {28'd0, e_irq});
      chk("spurious (R9)", {31'd0, spurious}, {31'd0, e_spur});
      chk("reg_rdata (R10)", reg_rdata, e_rd);
    end
  end

  always @(posedge clk) begin
    if (cyc_n > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc_n);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(input bit vv, input int vi, input bit we, input bit re,
                      input int a, input logic [31:0] wd);
    vec_valid = vv; vec_index = 8'(vi);
    reg_we = we; reg_re = re; reg_addr = 8'(a); reg_wdata = wd;
    @(negedge clk);
  endtask
  task automatic wr(input int a, input logic [31:0] d); step(0, 0, 1, 0, a, d); endtask
  task automatic rd(input int a);                       step(0, 0, 0, 1, a, 0); endtask
  task automatic vec(input int v);                      step(1, v, 0, 0, 0, 0); endtask
  task automatic idle();                                step(0, 0, 0, 0, 0, 0); endtask

  initial begin
    rst = 1; vec_valid = 0; vec_index = 0; reg_addr = 0;
    reg_we = 0; reg_re = 0; reg_wdata = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: everything reads zero after reset
    tag = "R1";
    for (int a = 0; a < 64; a += 4) rd(a);
    idle();

    // R2: enable words take and return full patterns
    tag = "R2";
    for (int g = 0; g < 8; g++) wr(32 + 4*g, 32'hA5A5_0000 ^ (32'h1111_1111 * g));
    for (int g = 0; g < 8; g++) rd(32 + 4*g);
    for (int g = 0; g < 8; g++) wr(32 + 4*g, 0);

    // R3: enabled vectors land in the right group and bit
    tag = "R3";
    wr(32, 32'h0000_FFFF);
    wr(32 + 20, 32'h0000_0080);
    wr(32 + 28, 32'h8000_0000);
    vec(3); vec(15); vec(167); vec(255);
    rd(0); rd(20); rd(28);
    step(1, 0, 0, 1, 0, 0);   // read in the same cycle as an arrival: old value
    rd(0);

    // R4: disabled vectors are dropped
    tag = "R4";
    vec(20); vec(100); vec(254);
    rd(0); rd(12); rd(28); idle();

    // R5: write-one-clear, zeros leave bits alone
    tag = "R5";
    wr(0, 32'h0000_0008);
    rd(0);
    wr(0, 32'h0000_0000);
    rd(0);
    wr(20, 32'hFFFF_FFFF); wr(28, 32'hFFFF_FFFF);
    rd(20); rd(28);

    // R7: lines fall once everything is retired
    tag = "R7";
    wr(0, 32'hFFFF_FFFF);
    idle(); idle();
    vec(7); idle(); idle();
    wr(0, 32'h0000_0080); idle(); idle();

    // R6: same-edge clear and arrival on one bit
    tag = "R6";
    vec(5); idle();
    step(1, 5, 1, 0, 0, 32'h0000_0020);
    rd(0);
    step(1, 6, 1, 0, 0, 32'h0000_0020);   // clear bit 5, set bit 6
    rd(0);
    wr(0, 32'hFFFF_FFFF); idle(); idle();

    // enable write and arrival at one edge: old enable governs
    tag = "R3";
    step(1, 33, 1, 0, 36, 32'h0000_0002);
    rd(4);
    vec(33); rd(4);
    wr(4, 32'hFFFF_FFFF); wr(36, 0); idle();

    // R9: bit above the legacy range in group 0
    tag = "R9";
    wr(32, 32'hFFFF_FFFF);
    vec(20); idle(); idle();
    vec(2); wr(0, 32'h0010_0000); idle(); idle();
    wr(0, 32'hFFFF_FFFF); idle(); idle();

    // R8: unmapped offsets
    tag = "R8";
    vec(9);
    wr(64, 32'hFFFF_FFFF); wr(33, 32'h0); wr(1, 32'hFFFF_FFFF); wr(252, 32'h0);
    rd(64); rd(34); rd(252); rd(2);
    rd(0); rd(32);

    // R10: idle cycles return zero data
    tag = "R10";
    rd(32); idle(); idle(); rd(0); idle();

    repeat (3) idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule